// File: doc/BRIEF.md
# Adder with Status Flag Generation

This unit adds two 64-bit operands and produces the status record that integer additions leave behind. The record has five flags: a 64-bit carry, a 32-bit carry, a 64-bit signed overflow, a 32-bit signed overflow, and a sticky summary-overflow. The first operand can be inverted before the add, which gives subtract-style forms. The carry-in comes from a small selector. Two enables decide whether the carry pair or the overflow pair is written. Whenever any flag changes, a status-write enable is raised. The full record always goes downstream with the result, so a later condition-field update can read the summary bit.

The unit feeds its own last-written record straight back to its input side. Two back-to-back instructions therefore see each other's flags without a stall. The second instruction starts from the record the first one produced, and the decoded record that may be one write behind is ignored. The same unit also handles moves between the record and a 64-bit special register image. The flags sit at fixed bit positions in that image, and every other bit is zero.

Top module: `add_flag_unit`

## Requirements
- R1: While `rst` is high on a rising edge, the next cycle shows `out_valid`=0, `stat_we`=0, `stat_out`=0 and `result`=0.
- R2: For an add (`op`=00, or the reserved `op`=11), `result` one cycle later equals A'+B+cin modulo 2^64. A' is `opnd_a` when `inv_a`=0 and its bitwise complement when `inv_a`=1.
- R3: The carry-in select `cin_sel` gives: 00 a carry-in of 0, 01 a carry-in of 1, 10 the CA flag of the starting record, 11 a carry-in of 0.
- R4: With `carry_en`=1, an add writes CA (the carry out of bit 63) and CA32 (the carry out of bit 31 into bit 32). With `carry_en`=0, both keep their starting values.
- R5: With `ov_en`=1, an add writes OV (signed overflow of the 64-bit add) and OV32 (signed overflow of the low 32-bit add). SO becomes 1 when OV is 1 and otherwise keeps its starting value. With `ov_en`=0, OV, OV32 and SO all keep their starting values.
- R6: `stat_we` is 1 exactly when a valid instruction wrote at least one flag. `stat_out` always carries the full record, with unwritten flags equal to the starting record. A cycle with `in_valid`=0 gives `out_valid`=0 and `stat_we`=0.
- R7: The starting record is the registered `stat_out` when the registered `stat_we` is 1. Otherwise it is `stat_in`.
- R8: A move-from (`op`=10) returns the starting record in `result` with SO at bit 31, OV at bit 30, CA at bit 29, OV32 at bit 19 and CA32 at bit 18. All other bits are zero. It leaves `stat_we`=0.
- R9: A move-to (`op`=01) loads the five flags from the same bit positions of `opnd_b`, ignores every other bit, sets `stat_we`=1 and gives `result`=0.
- R10: In `stat_in` and `stat_out` the bit order is [4] SO, [3] OV, [2] CA, [1] OV32, [0] CA32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op | input | 2 | 00 add, 01 move-to, 10 move-from, 11 add |
| opnd_a | input | 64 | First add operand |
| opnd_b | input | 64 | Second add operand, or the move-to source |
| inv_a | input | 1 | Complement `opnd_a` before the add |
| cin_sel | input | 2 | Carry-in select |
| carry_en | input | 1 | Write CA and CA32 |
| ov_en | input | 1 | Write OV, OV32 and SO |
| stat_in | input | 5 | Decoded status record |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Sum, or the move-from image |
| stat_out | output | 5 | Registered status record |
| stat_we | output | 1 | Status record was written |

## Verification
Every result, flag and enable comes from one register stage, so each output is due one rising edge after its inputs are applied. Forwarded state takes effect on the instruction in the very next cycle. The driver applies one instruction per falling edge and queues the expected outputs. The monitor takes that item off the queue a quarter period after the following rising edge, so every comparison looks at exactly the cycle the register stage fills. Forwarding is covered by back-to-back sequences in which `stat_in` deliberately disagrees with the last written record, and by a bubble that must break the chain.

// File: rtl/add_flag_pkg.sv
package add_flag_pkg;

    // Status record, most significant field first
    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
        logic ov32;
        logic ca32;
    } stat_rec_t;

    localparam int STAT_W = $bits(stat_rec_t);

    typedef enum logic [1:0] {
        OPC_ADD       = 2'b00,
        OPC_MOVE_TO   = 2'b01,
        OPC_MOVE_FROM = 2'b10,
        OPC_ADD_ALT   = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'b00,
        CIN_ONE   = 2'b01,
        CIN_CARRY = 2'b10,
        CIN_RSVD  = 2'b11
    } cin_e;

    // Positions in the special register image (bit 63 is the MSB)
    localparam int POS_SO   = 31;
    localparam int POS_OV   = 30;
    localparam int POS_CA   = 29;
    localparam int POS_OV32 = 19;
    localparam int POS_CA32 = 18;

    function automatic logic pick_cin(input cin_e sel, input stat_rec_t base);
        case (sel)
            CIN_ONE:   return 1'b1;
            CIN_CARRY: return base.ca;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic is_add(input opc_e o);
        return (o == OPC_ADD) || (o == OPC_ADD_ALT);
    endfunction

endpackage

// File: rtl/add_core.sv
module add_core
    import add_flag_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             inv,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_full,
    output logic             c_half,
    output logic             v_full,
    output logic             v_half
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        a_eff  = inv ? ~a : a;
        wide   = {1'b0, a_eff} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        sum    = wide[WIDTH-1:0];
        c_full = wide[WIDTH];
        // carry entering the upper half, recovered from the sum bit
        c_half = wide[HALF] ^ a_eff[HALF] ^ b[HALF];
        v_full = (c_full ^ wide[WIDTH-1]) & ~(a_eff[WIDTH-1] ^ b[WIDTH-1]);
        v_half = (c_half ^ wide[HALF-1]) & ~(a_eff[HALF-1] ^ b[HALF-1]);
    end

endmodule

// File: rtl/stat_word_map.sv
module stat_word_map
    import add_flag_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  stat_rec_t        rec,
    output logic [WIDTH-1:0] word
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == POS_SO) begin : g_so
            assign word[i] = rec.so;
        end else if (i == POS_OV) begin : g_ov
            assign word[i] = rec.ov;
        end else if (i == POS_CA) begin : g_ca
            assign word[i] = rec.ca;
        end else if (i == POS_OV32) begin : g_ov32
            assign word[i] = rec.ov32;
        end else if (i == POS_CA32) begin : g_ca32
            assign word[i] = rec.ca32;
        end else begin : g_zero
            assign word[i] = 1'b0;
        end
    end

endmodule

// File: rtl/flag_update.sv
module flag_update
    import add_flag_pkg::*;
(
    input  opc_e      opc,
    input  stat_rec_t base,
    input  logic      carry_en,
    input  logic      ov_en,
    input  logic      c_full,
    input  logic      c_half,
    input  logic      v_full,
    input  logic      v_half,
    input  stat_rec_t load_rec,
    output stat_rec_t next_rec,
    output logic      write
);
    always_comb begin
        next_rec = base;
        write    = 1'b0;
        if (opc == OPC_MOVE_TO) begin
            next_rec = load_rec;
            write    = 1'b1;
        end else if (is_add(opc)) begin
            if (carry_en) begin
                next_rec.ca   = c_full;
                next_rec.ca32 = c_half;
                write         = 1'b1;
            end
            if (ov_en) begin
                next_rec.ov   = v_full;
                next_rec.ov32 = v_half;
                next_rec.so   = base.so | v_full;
                write         = 1'b1;
            end
        end
    end

endmodule

// File: rtl/add_flag_unit.sv
module add_flag_unit
    import add_flag_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             inv_a,
    input  logic [1:0]       cin_sel,
    input  logic             carry_en,
    input  logic             ov_en,
    input  logic [4:0]       stat_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic [4:0]       stat_out,
    output logic             stat_we
);
    opc_e             opc;
    stat_rec_t        stat_q;
    stat_rec_t        base;
    stat_rec_t        load_rec;
    stat_rec_t        next_rec;
    logic             we_nxt;
    logic             cin;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] image;
    logic [WIDTH-1:0] res_nxt;
    logic             c_full, c_half, v_full, v_half;

    assign opc = opc_e'(op);

    // own previous write wins over the decoded record
    assign base = stat_we ? stat_q : stat_rec_t'(stat_in);
    assign cin  = pick_cin(cin_e'(cin_sel), base);

    assign load_rec = '{so:   opnd_b[POS_SO],
                        ov:   opnd_b[POS_OV],
                        ca:   opnd_b[POS_CA],
                        ov32: opnd_b[POS_OV32],
                        ca32: opnd_b[POS_CA32]};

    add_core #(.WIDTH(WIDTH)) u_core (
        .a      (opnd_a),
        .b      (opnd_b),
        .inv    (inv_a),
        .cin    (cin),
        .sum    (sum),
        .c_full (c_full),
        .c_half (c_half),
        .v_full (v_full),
        .v_half (v_half)
    );

    stat_word_map #(.WIDTH(WIDTH)) u_map (
        .rec  (base),
        .word (image)
    );

    flag_update u_upd (
        .opc      (opc),
        .base     (base),
        .carry_en (carry_en),
        .ov_en    (ov_en),
        .c_full   (c_full),
        .c_half   (c_half),
        .v_full   (v_full),
        .v_half   (v_half),
        .load_rec (load_rec),
        .next_rec (next_rec),
        .write    (we_nxt)
    );

    always_comb begin
        case (opc)
            OPC_MOVE_FROM: res_nxt = image;
            OPC_MOVE_TO:   res_nxt = '0;
            default:       res_nxt = sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            stat_q    <= '0;
            stat_we   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= res_nxt;
                stat_q  <= next_rec;
                stat_we <= we_nxt;
            end else begin
                stat_we <= 1'b0;
            end
        end
    end

    assign stat_out = stat_q;

endmodule

// File: rtl/add_flag_unit_chk.sv
module add_flag_unit_chk
    import add_flag_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       op,
    input logic             carry_en,
    input logic             ov_en,
    input logic [4:0]       mt_bits,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic [4:0]       stat_out,
    input logic             stat_we
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] MAP_MASK = (ONE << POS_SO) | (ONE << POS_OV) |
        (ONE << POS_CA) | (ONE << POS_OV32) | (ONE << POS_CA32);

    logic add_op;
    assign add_op = (op == OPC_ADD) || (op == OPC_ADD_ALT);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !stat_we && stat_out == 5'd0 && result == '0));

    a_r6_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
        stat_we |-> out_valid);

    a_r6_bubble_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !stat_we));

    a_r6_no_enable_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && add_op && !carry_en && !ov_en) |=> !stat_we);

    a_r5_oe_writes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && add_op && ov_en) |=> stat_we);

    // R7: a forwarded SO can never be lost by a following add or move-from
    a_r7_so_kept_forward: assert property (@(posedge clk) disable iff (rst)
        (stat_we && in_valid && op != OPC_MOVE_TO) |=> (stat_out[4] || !$past(stat_out[4])));

    a_r8_from_clean: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OPC_MOVE_FROM) |=> (!stat_we && (result & ~MAP_MASK) == '0));

    a_r9_to_loads: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OPC_MOVE_TO) |=> (stat_we && result == '0 && stat_out == $past(mt_bits)));

endmodule

bind add_flag_unit add_flag_unit_chk #(.WIDTH(WIDTH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .carry_en  (carry_en),
    .ov_en     (ov_en),
    .mt_bits   ({opnd_b[add_flag_pkg::POS_SO], opnd_b[add_flag_pkg::POS_OV],
                 opnd_b[add_flag_pkg::POS_CA], opnd_b[add_flag_pkg::POS_OV32],
                 opnd_b[add_flag_pkg::POS_CA32]}),
    .out_valid (out_valid),
    .result    (result),
    .stat_out  (stat_out),
    .stat_we   (stat_we)
);

// File: tb/test_add_flag_unit.sv
module test_add_flag_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [63:0] opnd_a, opnd_b;
    logic        inv_a;
    logic [1:0]  cin_sel;
    logic        carry_en, ov_en;
    logic [4:0]  stat_in;
    logic        out_valid;
    logic [63:0] result;
    logic [4:0]  stat_out;
    logic        stat_we;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // scoreboard queues
    logic        q_vld[$];
    logic [63:0] q_res[$];
    logic [4:0]  q_st[$];
    logic        q_we[$];
    string       q_req[$];

    // reference state: last written record
    logic       m_we = 1'b0;
    logic [4:0] m_st = 5'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    add_flag_unit i_add_flag_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .inv_a(inv_a), .cin_sel(cin_sel),
        .carry_en(carry_en), .ov_en(ov_en), .stat_in(stat_in),
        .out_valid(out_valid), .result(result), .stat_out(stat_out), .stat_we(stat_we)
    );

    task automatic issue(input logic v, input logic [1:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic inv, input logic [1:0] cs,
                         input logic ce, input logic oe, input logic [4:0] si,
                         input string req);
        logic [4:0]  base, st;
        logic [63:0] ae, res;
        logic [64:0] w64;
        logic [32:0] w32;
        logic        cin, we;
        @(negedge clk);
        in_valid = v; op = o; opnd_a = a; opnd_b = b; inv_a = inv;
        cin_sel = cs; carry_en = ce; ov_en = oe; stat_in = si;
        base = m_we ? m_st : si;           // R7
        st = base; res = 64'd0; we = 1'b0;
        if (v) begin
            if (o == 2'b01) begin           // R9
                st = {b[31], b[30], b[29], b[19], b[18]};
                we = 1'b1;
            end else if (o == 2'b10) begin  // R8
                res = 64'd0;
                res[31] = base[4]; res[30] = base[3]; res[29] = base[2];
                res[19] = base[1]; res[18] = base[0];
            end else begin                  // R2, R3, R4, R5
                ae  = inv ? ~a : a;
                cin = (cs == 2'b01) ? 1'b1 : (cs == 2'b10) ? base[2] : 1'b0;
                w64 = {1'b0, ae} + {1'b0, b} + {64'd0, cin};
                w32 = {1'b0, ae[31:0]} + {1'b0, b[31:0]} + {32'd0, cin};
                res = w64[63:0];
                if (ce) begin
                    st[2] = w64[64];
                    st[0] = w32[32];
                    we = 1'b1;
                end
                if (oe) begin
                    st[3] = (ae[63] == b[63]) && (res[63] != ae[63]);
                    st[1] = (ae[31] == b[31]) && (res[31] != ae[31]);
                    st[4] = base[4] | st[3];
                    we = 1'b1;
                end
            end
            m_st = st;
        end
        m_we = v & we;
        q_vld.push_back(v); q_res.push_back(res); q_st.push_back(st);
        q_we.push_back(v & we); q_req.push_back(req);
    endtask

    task automatic add(input logic [63:0] a, input logic [63:0] b, input logic inv,
                       input logic [1:0] cs, input logic ce, input logic oe,
                       input logic [4:0] si, input string req);
        issue(1'b1, 2'b00, a, b, inv, cs, ce, oe, si, req);
    endtask

    task automatic bubble(input string req);
        issue(1'b0, 2'b00, 64'd0, 64'd0, 1'b0, 2'b00, 1'b0, 1'b0, 5'd0, req);
    endtask

    // monitor: one registered stage, sample a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_vld.size() > 0) begin
                logic        e_v, e_w, bad;
                logic [63:0] e_r;
                logic [4:0]  e_s;
                string       rq;
                e_v = q_vld.pop_front(); e_r = q_res.pop_front();
                e_s = q_st.pop_front();  e_w = q_we.pop_front();
                rq  = q_req.pop_front();
                checks++;
                if (e_v)
                    bad = (out_valid !== 1'b1) || (result !== e_r) ||
                          (stat_out !== e_s) || (stat_we !== e_w);
                else
                    bad = (out_valid !== 1'b0) || (stat_we !== 1'b0);
                if (bad) begin
                    errors++;
                    $display("FAIL %s: got valid=%b result=%h stat=%b we=%b, expected valid=%b result=%h stat=%b we=%b",
                             rq, out_valid, result, stat_out, stat_we, e_v, e_r, e_s, e_w);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 2'b00; opnd_a = '0; opnd_b = '0;
        inv_a = 1'b0; cin_sel = 2'b00; carry_en = 1'b0; ov_en = 1'b0; stat_in = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R1 reset state
        if (out_valid !== 1'b0 || stat_we !== 1'b0 || stat_out !== 5'd0 || result !== 64'd0) begin
            errors++;
            $display("FAIL R1: got valid=%b we=%b stat=%b result=%h, expected all zero",
                     out_valid, stat_we, stat_out, result);
        end
        rst = 1'b0;

        add(64'd5, 64'd7, 1'b0, 2'b00, 1'b0, 1'b0, 5'b10100, "R2 plain add, R6 record passed");
        add(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 2'b00, 1'b1, 1'b0, 5'd0, "R4 full carry");
        add(64'd0, 64'd0, 1'b0, 2'b10, 1'b0, 1'b0, 5'd0, "R7 forwarded CA as carry-in");
        add(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 2'b00, 1'b1, 1'b0, 5'd0, "R4 half carry only");
        bubble("R6 bubble");
        add(64'd10, 64'd20, 1'b0, 2'b10, 1'b0, 1'b0, 5'b00100, "R3 carry-in from CA after bubble");
        add(64'd10, 64'd20, 1'b0, 2'b01, 1'b0, 1'b0, 5'd0, "R3 carry-in one");
        add(64'd10, 64'd20, 1'b0, 2'b11, 1'b0, 1'b0, 5'd0, "R3 reserved select is zero");
        add(64'd3, 64'd10, 1'b1, 2'b01, 1'b1, 1'b0, 5'd0, "R2 inverted operand subtract");
        add(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 2'b00, 1'b0, 1'b1, 5'd0, "R5 64-bit overflow sets SO");
        add(64'd1, 64'd1, 1'b0, 2'b00, 1'b0, 1'b1, 5'd0, "R5 SO sticky via R7 forward");
        add(64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, 2'b00, 1'b0, 1'b1, 5'd0, "R5 32-bit overflow only");
        issue(1'b1, 2'b10, 64'd0, 64'd0, 1'b0, 2'b00, 1'b0, 1'b0, 5'd0, "R8 move-from forwarded record");
        issue(1'b1, 2'b01, 64'd0, (64'd1 << 31) | (64'd1 << 18) | (64'd1 << 40) | 64'd1,
              1'b0, 2'b00, 1'b0, 1'b0, 5'b01110, "R9 move-to ignores other bits");
        issue(1'b1, 2'b10, 64'd0, 64'd0, 1'b0, 2'b00, 1'b0, 1'b0, 5'b11111, "R8 move-from after move-to (R7)");
        issue(1'b1, 2'b01, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'b00, 1'b0, 1'b0, 5'd0, "R9 move-to all ones");
        bubble("R6 bubble breaks forwarding");
        issue(1'b1, 2'b10, 64'd0, 64'd0, 1'b0, 2'b00, 1'b0, 1'b0, 5'b01010, "R8 move-from decoded record, R10 order");
        add(64'd2, 64'd3, 1'b0, 2'b00, 1'b0, 1'b1, 5'b10000, "R5 SO kept from decoded record");
        issue(1'b1, 2'b11, 64'd4, 64'd9, 1'b0, 2'b00, 1'b1, 1'b1, 5'd0, "R2 reserved op adds");

        for (int i = 0; i < 60; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 5 == 0) ra[62:0] = {63{ra[63]}};
            add(ra, rb, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                5'($urandom), "R2 R4 R5 R7 mixed");
            if (i % 9 == 0) bubble("R6 bubble in mix");
        end

        @(negedge clk);
        in_valid = 1'b0;
        while (q_vld.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule